// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a shared two-port RAM. It compares the address and enable of a left port and a right port on every clock cycle. When both ports are enabled and point at the same word, it picks one port to wait by pulling that port's active-low busy flag. It also produces a per-port write inhibit and a gated write enable, which stop the waiting port's write strobe from reaching the array. The port whose inputs were already in place keeps access. The port that arrived later waits. If both arrive in the same cycle, the left port wins. The choice is kept until the collision ends.

The block has two configurations, set by `cfg_master`. As a master it drives both busy flags itself. As a slave it drives both busy flags inactive and takes its write inhibits from two external active-low busy inputs, which usually come from a master instance.

A port's inputs count as "fresh" in a cycle when its enable or its address differs from the value it had in the previous cycle. The arbitration state machine has three states:
- `ARB_IDLE`: no verdict is held.
- `ARB_LT_HOLDS`: the left port has access and the right port waits.
- `ARB_RT_HOLDS`: the right port has access and the left port waits.

The transitions are:
- IDLE to LT_HOLDS on a collision where the left port is stale or the arrival is a tie.
- IDLE to RT_HOLDS on a collision where only the left port is fresh.
- From either HOLDS state back to IDLE when the collision ends.
- Each HOLDS state to itself while the collision persists.

The busy verdict is combinational in the first cycle of a collision, so that cycle's write is already blocked.

Top module: `dp_collide_arb`

## Requirements
- R1: In master mode, when the two port addresses differ, `lt_busy_n` and `rt_busy_n` are both 1 (inactive).
- R2: In master mode, when the addresses match but `lt_en_n` or `rt_en_n` is 1 (inactive), both busy flags are 1.
- R3: When both enables are 0 and the addresses match in a cycle where exactly one port is fresh (its enable or address changed since the previous cycle), the busy flag of the fresh port is 0 in that same cycle and the other flag is 1.
- R4: On a collision where both ports are fresh or both are stale, the left port wins: `rt_busy_n`=0 and `lt_busy_n`=1.
- R5: `lt_busy_n` and `rt_busy_n` are never 0 in the same cycle.
- R6: Once a port is flagged busy, its flag stays 0 while the collision lasts. This holds even if both addresses move together to a new common value. The flag returns to 1 in the first cycle of mismatch or of an inactive enable.
- R7: In master mode a port's write inhibit is 1 exactly when its own busy output is 0, and the external busy inputs have no effect.
- R8: In slave mode (`cfg_master`=0) both busy outputs are 1. Each port's write inhibit is 1 exactly when that port's external busy input is 0.
- R9: While `rst_n` is 0, both busy outputs are 1, even if the inputs collide.
- R10: A port's write enable output is 1 exactly when its enable is 0, its write strobe `*_wr_n` is 0 and its write inhibit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 = master (drives busy), 0 = slave (uses external busy) |
| lt_en_n | input | 1 | Left port enable, active low |
| lt_wr_n | input | 1 | Left port write strobe, active low |
| lt_addr | input | ADDR_W | Left port address (12 bits by default) |
| rt_en_n | input | 1 | Right port enable, active low |
| rt_wr_n | input | 1 | Right port write strobe, active low |
| rt_addr | input | ADDR_W | Right port address |
| lt_busy_in_n | input | 1 | External busy for the left port (slave mode), active low |
| rt_busy_in_n | input | 1 | External busy for the right port (slave mode), active low |
| lt_busy_n | output | 1 | Left port busy flag, active low |
| rt_busy_n | output | 1 | Right port busy flag, active low |
| lt_wr_inh | output | 1 | Left write inhibit, active high |
| rt_wr_inh | output | 1 | Right write inhibit, active high |
| lt_we | output | 1 | Gated left write enable to the RAM, active high |
| rt_we | output | 1 | Gated right write enable to the RAM, active high |

## Verification
The assertions check the following every cycle:
- that the two busy flags are mutually exclusive;
- that both flags are inactive on a mismatch, on an inactive enable and in slave mode;
- that a master-mode busy flag always blocks its port's write enable;
- that a held verdict survives any cycle in which the collision persists.

Which port loses, however, depends on the arrival history. Only the bench's scenarios show this: later arrival on either side, a tie, a joint address move during a hold, and slave-mode inhibits following the external pins.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE     = 2'd0,
        ARB_LT_HOLDS = 2'd1,
        ARB_RT_HOLDS = 2'd2
    } arb_state_e;
endpackage

// File: rtl/arb_port_track.sv
module arb_port_track #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              fresh
);
    logic              en_n_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_n_q <= 1'b1;
            addr_q <= '0;
        end else begin
            en_n_q <= en_n;
            addr_q <= addr;
        end
    end

    // Inputs differ from those seen one cycle earlier
    assign fresh = (en_n != en_n_q) || (addr != addr_q);
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic collide,
    input  logic lt_fresh,
    input  logic rt_fresh,
    output logic lt_wait,
    output logic rt_wait
);
    arb_state_e state_q, state_d;
    logic       lt_later;

    // Left loses only when it alone is new; ties go to the left port
    assign lt_later = lt_fresh && !rt_fresh;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:     if (collide) state_d = lt_later ? ARB_RT_HOLDS : ARB_LT_HOLDS;
            ARB_LT_HOLDS: if (!collide) state_d = ARB_IDLE;
            ARB_RT_HOLDS: if (!collide) state_d = ARB_IDLE;
            default:      state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        lt_wait = 1'b0;
        rt_wait = 1'b0;
        if (rst_n && collide) begin
            unique case (state_q)
                ARB_IDLE: begin
                    lt_wait = lt_later;
                    rt_wait = !lt_later;
                end
                ARB_LT_HOLDS: rt_wait = 1'b1;
                ARB_RT_HOLDS: lt_wait = 1'b1;
                default: ;
            endcase
        end
    end

    AST_WAIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lt_wait && rt_wait)); // R5
    AST_HOLD_RT: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_wait && collide) |=> (!collide || rt_wait)); // R6
    AST_HOLD_LT: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_wait && collide) |=> (!collide || lt_wait)); // R6
endmodule

// File: rtl/arb_wr_gate.sv
module arb_wr_gate (
    input  logic master,
    input  logic own_wait,
    input  logic ext_busy_n,
    input  logic en_n,
    input  logic wr_n,
    output logic inh,
    output logic we
);
    assign inh = master ? own_wait : !ext_busy_n;
    assign we  = !en_n && !wr_n && !inh;
endmodule

// File: rtl/dp_collide_arb.sv
module dp_collide_arb #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              lt_en_n,
    input  logic              lt_wr_n,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              rt_en_n,
    input  logic              rt_wr_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              lt_busy_in_n,
    input  logic              rt_busy_in_n,
    output logic              lt_busy_n,
    output logic              rt_busy_n,
    output logic              lt_wr_inh,
    output logic              rt_wr_inh,
    output logic              lt_we,
    output logic              rt_we
);
    logic collide, lt_fresh, rt_fresh, lt_wait, rt_wait;

    assign collide = !lt_en_n && !rt_en_n && (lt_addr == rt_addr);

    arb_port_track #(.ADDR_W(ADDR_W)) u_lt_track (
        .clk(clk), .rst_n(rst_n), .en_n(lt_en_n), .addr(lt_addr), .fresh(lt_fresh));
    arb_port_track #(.ADDR_W(ADDR_W)) u_rt_track (
        .clk(clk), .rst_n(rst_n), .en_n(rt_en_n), .addr(rt_addr), .fresh(rt_fresh));

    arb_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .collide(collide),
        .lt_fresh(lt_fresh), .rt_fresh(rt_fresh),
        .lt_wait(lt_wait), .rt_wait(rt_wait));

    assign lt_busy_n = !(cfg_master && lt_wait);
    assign rt_busy_n = !(cfg_master && rt_wait);

    arb_wr_gate u_lt_gate (
        .master(cfg_master), .own_wait(lt_wait), .ext_busy_n(lt_busy_in_n),
        .en_n(lt_en_n), .wr_n(lt_wr_n), .inh(lt_wr_inh), .we(lt_we));
    arb_wr_gate u_rt_gate (
        .master(cfg_master), .own_wait(rt_wait), .ext_busy_n(rt_busy_in_n),
        .en_n(rt_en_n), .wr_n(rt_wr_n), .inh(rt_wr_inh), .we(rt_we));

    AST_NO_DUAL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lt_busy_n && !rt_busy_n)); // R5
    AST_MISMATCH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_addr != rt_addr) |-> (lt_busy_n && rt_busy_n)); // R1
    AST_DISABLED_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_en_n || rt_en_n) |-> (lt_busy_n && rt_busy_n)); // R2
    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> (lt_busy_n && rt_busy_n)); // R8
    AST_LT_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !lt_busy_n) |-> !lt_we); // R7
    AST_RT_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !rt_busy_n) |-> !rt_we); // R7
endmodule

// File: tb/test_dp_collide_arb.sv
module test_dp_collide_arb;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_master = 1'b1;
    logic lt_en_n = 1'b1, lt_wr_n = 1'b1, rt_en_n = 1'b1, rt_wr_n = 1'b1;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic lt_busy_in_n = 1'b1, rt_busy_in_n = 1'b1;
    logic lt_busy_n, rt_busy_n, lt_wr_inh, rt_wr_inh, lt_we, rt_we;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    dp_collide_arb #(.ADDR_W(AW)) i_dp_collide_arb (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
        .lt_en_n(lt_en_n), .lt_wr_n(lt_wr_n), .lt_addr(lt_addr),
        .rt_en_n(rt_en_n), .rt_wr_n(rt_wr_n), .rt_addr(rt_addr),
        .lt_busy_in_n(lt_busy_in_n), .rt_busy_in_n(rt_busy_in_n),
        .lt_busy_n(lt_busy_n), .rt_busy_n(rt_busy_n),
        .lt_wr_inh(lt_wr_inh), .rt_wr_inh(rt_wr_inh),
        .lt_we(lt_we), .rt_we(rt_we));

    function automatic logic [5:0] outs();
        return {lt_busy_n, rt_busy_n, lt_wr_inh, rt_wr_inh, lt_we, rt_we};
    endfunction

    task automatic check(input logic [5:0] act, input logic [5:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got {bl,br,il,ir,wl,wr}=%b expected %b", tag, act, exp);
        end
    endtask

    // Driver: one call per cycle; expected busy given, the rest derived from R7, R8, R10
    task automatic step(input logic m, input logic le, input logic lw, input int la,
                        input logic re, input logic rw, input int ra,
                        input logic ebl, input logic ebr,
                        input logic xbl, input logic xbr, input string tag);
        logic il, ir, wl, wr;
        exp_t e;
        @(negedge clk);
        cfg_master = m;
        lt_en_n = le; lt_wr_n = lw; lt_addr = AW'(la);
        rt_en_n = re; rt_wr_n = rw; rt_addr = AW'(ra);
        lt_busy_in_n = ebl; rt_busy_in_n = ebr;
        il = m ? !xbl : !ebl;
        ir = m ? !xbr : !ebr;
        wl = !le && !lw && !il;
        wr = !re && !rw && !ir;
        e.exp = {xbl, xbr, il, ir, wl, wr};
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: samples late in each cycle, before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(outs(), e.exp, e.tag);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R9: colliding inputs held in reset
        lt_en_n = 1'b0; rt_en_n = 1'b0; lt_addr = 12'h0AB; rt_addr = 12'h0AB;
        repeat (3) @(posedge clk);
        #2;
        check({lt_busy_n, rt_busy_n}, 2'b11, "R9 reset busy idle");
        @(negedge clk);
        rst_n = 1'b1;
        //    m  le lw  la  re rw  ra  ebl ebr bl br
        step(1, 1, 1,  5,  1, 1,  5,  1, 1,  1, 1, "R2 both disabled");
        step(1, 0, 0,  5,  1, 1,  5,  1, 1,  1, 1, "R2/R10 left only, writes");
        step(1, 0, 0,  5,  0, 0,  7,  1, 1,  1, 1, "R1/R10 differ, both write");
        step(1, 0, 0,  5,  0, 0,  5,  1, 1,  1, 0, "R3/R7 right later");
        step(1, 0, 0,  5,  0, 0,  5,  1, 1,  1, 0, "R6 hold");
        step(1, 0, 1,  9,  0, 0,  9,  1, 1,  1, 0, "R6 joint move");
        step(1, 0, 0,  9,  0, 0, 10,  1, 1,  1, 1, "R1/R6 release");
        step(1, 0, 0, 10,  0, 0, 10,  1, 1,  0, 1, "R3/R7 left later");
        step(1, 0, 0, 10,  1, 0, 10,  1, 1,  1, 1, "R2/R6 enable drop");
        step(1, 0, 1, 10,  0, 1, 10,  1, 1,  1, 0, "R3 right re-enables");
        step(1, 1, 1, 10,  1, 1, 10,  1, 1,  1, 1, "R2 both off");
        step(1, 0, 0,  3,  0, 0,  3,  0, 1,  1, 0, "R4/R7 tie, ext busy ignored");
        step(1, 0, 0,  3,  0, 0,  3,  0, 0,  1, 0, "R4/R7 stale tie, ext ignored");
        step(1, 1, 1,  3,  1, 1,  3,  1, 1,  1, 1, "R2 both off again");
        step(0, 0, 0,  4,  0, 0,  4,  0, 1,  1, 1, "R8 slave left ext busy");
        step(0, 0, 0,  4,  0, 0,  4,  1, 1,  1, 1, "R8/R10 slave no ext busy");
        step(0, 0, 0,  4,  0, 0,  4,  1, 0,  1, 1, "R8 slave right ext busy");
        step(1, 1, 1,  4,  1, 1,  4,  1, 1,  1, 1, "R2 back to master");
        step(1, 0, 0, 12'hFFF, 0, 0, 12'hFFE, 1, 1, 1, 1, "R1 top addresses");
        @(negedge clk);
        wait (sb.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule